// File: doc/BRIEF.md
# Capture Up-Counter Timer

This block is a 16-bit up-counting timer. Its count clock comes from one of four sources: rising edges of an external pin, or one of three single-cycle tick inputs from a shared prescaler. A mode register sets the count source and turns on clear-on-match against a compare register. It also picks how hardware captures happen. A capture copies the running count into one of two capture registers. The trigger is an edge of the external pin, or an edge of a neighbouring timer's output.

Software can also force a capture. It writes the mode register with the software-capture bit at zero, and the count goes into capture register 0 on that same clock edge. Every rising edge of the external pin raises a one-cycle interrupt pulse, whatever the capture mode. The external pin and the neighbour output each pass through a two-stage synchronizer before edge detection. All register access goes through a simple write/read port.

Top module: `capTimer`

## Requirements
- R1: After reset the counter, the compare register and both capture registers are zero, and the mode register (address 0) reads 0x20.
- R2: Mode bits [1:0] choose the count source: 00 = synchronized rising edge of extPin, 01 = tick1, 10 = tick4, 11 = tick16. The counter adds one for each event of the chosen source while runEn is high, and ticks of the other sources have no effect.
- R3: While runEn is low the counter holds its value, whatever the ticks do.
- R4: matchFlag is high whenever the counter equals the compare register (address 1). With mode bit 2 set, a count event at a match loads zero. With bit 2 clear, the counter runs freely and wraps from 0xFFFF to 0x0000.
- R5: With capture mode bits [4:3] = 00, pin edges leave both capture registers unchanged.
- R6: In capture mode 01, each synchronized rising edge of extPin loads the counter into capture register 0, and capture register 1 is left alone.
- R7: In capture mode 10, a rising edge of extPin loads capture register 0 and a falling edge loads capture register 1.
- R8: In capture mode 11, rising and falling edges of peerOut load capture registers 0 and 1, and extPin edges cause no capture.
- R9: A write to address 0 with bit 5 = 0 copies the counter value of that cycle into capture register 0 on the write edge. A write with bit 5 = 1 causes no capture. Bit 5 always reads 1.
- R10: irqPulse is high for exactly one cycle for each synchronized rising edge of extPin, in every capture mode.
- R11: Mode bits [7:6] read as 0 whatever value was written to them.
- R12: The read port returns the mode at address 0, the compare value at 1, capture 0 at 2, capture 1 at 3, the counter at 4, and zero at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr (combinational) |
| tick1 | input | 1 | Prescaler tap 1 tick |
| tick4 | input | 1 | Prescaler tap 4 tick |
| tick16 | input | 1 | Prescaler tap 16 tick |
| extPin | input | 1 | External count/capture pin (asynchronous) |
| peerOut | input | 1 | Neighbouring timer output (asynchronous) |
| runEn | input | 1 | Count enable |
| countVal | output | 16 | Current counter value |
| capVal0 | output | 16 | Capture register 0 |
| capVal1 | output | 16 | Capture register 1 |
| matchFlag | output | 1 | Counter equals compare register |
| irqPulse | output | 1 | One-cycle pulse per extPin rising edge |

## Verification
The hardest case to reach is the counter wrapping from 0xFFFF to zero while clear-on-match is off. It needs 65536 count events. The stimulus gets there by holding tick1 high for exactly that many cycles and then checking that the counter is back at the value it started from. Capture timing through the synchronizer is also hard to pin down from outside. The bench drives each pin in wide pulses that last several cycles. A reference model, driven only by the same port values, predicts on every clock which counter value each edge should capture.

// File: rtl/capTimerPkg.sv
package capTimerPkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 8;
  localparam int SWCAP_BIT = 5;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CAP0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAP1 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd4;

  typedef enum logic [1:0] {
    SRC_PIN = 2'b00,
    SRC_T1  = 2'b01,
    SRC_T4  = 2'b10,
    SRC_T16 = 2'b11
  } clkSrc_e;

  typedef enum logic [1:0] {
    CAP_OFF       = 2'b00,
    CAP_PIN_RISE  = 2'b01,
    CAP_PIN_BOTH  = 2'b10,
    CAP_PEER_BOTH = 2'b11
  } capMode_e;

  // stored mode fields, bit order matches the write data layout
  typedef struct packed {
    capMode_e capMode;   // bits [4:3]
    logic     clrEn;     // bit 2
    clkSrc_e  clkSel;    // bits [1:0]
  } modeCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic countEn;
    logic clearCnt;
    logic cap0Load;
    logic cap1Load;
    logic cmpLoad;
  } dpStrobe_t;
endpackage

// File: rtl/capTimerEdge.sv
module capTimerEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseEvt,
  output logic fallEvt
);
  logic [STAGES-1:0] syncQ;
  logic lastQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[STAGES-2:0], pinIn};
      lastQ <= syncQ[STAGES-1];
    end
  end

  assign riseEvt = syncQ[STAGES-1] & ~lastQ;
  assign fallEvt = ~syncQ[STAGES-1] & lastQ;
endmodule

// File: rtl/capTimerCtl.sv
module capTimerCtl
  import capTimerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tick1,
  input  logic              tick4,
  input  logic              tick16,
  input  logic              extPin,
  input  logic              peerOut,
  input  logic              runEn,
  input  logic              cntMatch,
  output dpStrobe_t         strobes,
  output logic [MODE_W-1:0] modeRead,
  output logic              irqPulse
);
  localparam int NUM_EDGE = 2;   // index 0: extPin, index 1: peerOut
  localparam int CFG_W = $bits(modeCfg_t);

  modeCfg_t cfg;
  logic [NUM_EDGE-1:0] pinVec;
  logic [NUM_EDGE-1:0] riseVec;
  logic [NUM_EDGE-1:0] fallVec;
  logic modeWr;
  logic swCap;
  logic [3:0] tickVec;
  logic selTick;

  assign pinVec = {peerOut, extPin};

  for (genvar g = 0; g < NUM_EDGE; g++) begin : gEdge
    capTimerEdge #(.STAGES(SYNC_STAGES)) uEdge (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (pinVec[g]),
      .riseEvt(riseVec[g]),
      .fallEvt(fallVec[g])
    );
  end

  assign modeWr = wrEn && (addr == ADDR_MODE);
  assign swCap  = modeWr && !wrData[SWCAP_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '{capMode: CAP_OFF, clrEn: 1'b0, clkSel: SRC_PIN};
    end else if (modeWr) begin
      cfg <= modeCfg_t'(wrData[CFG_W-1:0]);
    end
  end

  assign modeRead = {2'b00, 1'b1, cfg};

  assign tickVec = {tick16, tick4, tick1, riseVec[0]};
  assign selTick = tickVec[cfg.clkSel];

  always_comb begin
    strobes          = '0;
    strobes.countEn  = runEn & selTick;
    strobes.clearCnt = runEn & selTick & cfg.clrEn & cntMatch;
    strobes.cmpLoad  = wrEn && (addr == ADDR_CMP);
    strobes.cap0Load = swCap;
    unique case (cfg.capMode)
      CAP_OFF: ;
      CAP_PIN_RISE: strobes.cap0Load = swCap | riseVec[0];
      CAP_PIN_BOTH: begin
        strobes.cap0Load = swCap | riseVec[0];
        strobes.cap1Load = fallVec[0];
      end
      CAP_PEER_BOTH: begin
        strobes.cap0Load = swCap | riseVec[1];
        strobes.cap1Load = fallVec[1];
      end
      default: ;
    endcase
  end

  assign irqPulse = riseVec[0];
endmodule

// File: rtl/capTimerDp.sv
module capTimerDp
  import capTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] addr,
  input  logic [MODE_W-1:0] modeRead,
  output logic [CNT_W-1:0]  rdData,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  capVal0,
  output logic [CNT_W-1:0]  capVal1,
  output logic              cntMatch
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0] cap0;
  logic [CNT_W-1:0] cap1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobes.clearCnt) begin
      cnt <= '0;
    end else if (strobes.countEn) begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpVal <= '0;
    end else if (strobes.cmpLoad) begin
      cmpVal <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cap0 <= '0;
      cap1 <= '0;
    end else begin
      if (strobes.cap0Load) cap0 <= cnt;
      if (strobes.cap1Load) cap1 <= cnt;
    end
  end

  assign cntMatch = (cnt == cmpVal);

  always_comb begin
    unique case (addr)
      ADDR_MODE: rdData = {{(CNT_W-MODE_W){1'b0}}, modeRead};
      ADDR_CMP:  rdData = cmpVal;
      ADDR_CAP0: rdData = cap0;
      ADDR_CAP1: rdData = cap1;
      ADDR_CNT:  rdData = cnt;
      default:   rdData = '0;
    endcase
  end

  assign countVal = cnt;
  assign capVal0  = cap0;
  assign capVal1  = cap1;
endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              tick1,
  input  logic              tick4,
  input  logic              tick16,
  input  logic              extPin,
  input  logic              peerOut,
  input  logic              runEn,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  capVal0,
  output logic [CNT_W-1:0]  capVal1,
  output logic              matchFlag,
  output logic              irqPulse
);
  dpStrobe_t         strobes;
  logic [MODE_W-1:0] modeRead;
  logic              cntMatch;

  capTimerCtl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .tick1   (tick1),
    .tick4   (tick4),
    .tick16  (tick16),
    .extPin  (extPin),
    .peerOut (peerOut),
    .runEn   (runEn),
    .cntMatch(cntMatch),
    .strobes (strobes),
    .modeRead(modeRead),
    .irqPulse(irqPulse)
  );

  capTimerDp #(.CNT_W(CNT_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .addr    (addr),
    .modeRead(modeRead),
    .rdData  (rdData),
    .countVal(countVal),
    .capVal0 (capVal0),
    .capVal1 (capVal1),
    .cntMatch(cntMatch)
  );

  assign matchFlag = cntMatch;
endmodule

// File: rtl/capTimerChk.sv
module capTimerChk
  import capTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic              runEn,
  input logic [CNT_W-1:0]  countVal,
  input logic [CNT_W-1:0]  capVal0,
  input logic [CNT_W-1:0]  capVal1,
  input logic              irqPulse,
  input dpStrobe_t         strobes,
  input logic [MODE_W-1:0] modeRead
);
  logic swWrite;
  assign swWrite = wrEn && (addr == ADDR_MODE) && !wrData[SWCAP_BIT];

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countEn && !strobes.clearCnt |=> countVal == CNT_W'($past(countVal) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> countVal == $past(countVal));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> countVal == '0);

  assert_no_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeRead[4:3] == 2'b00) && !swWrite |=> $stable(capVal0) && $stable(capVal1));

  assert_sw_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    swWrite |=> capVal0 == $past(countVal));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  assert_mode_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    modeRead[7:6] == 2'b00 && modeRead[5]);
endmodule

bind capTimer capTimerChk #(.CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .runEn   (runEn),
  .countVal(countVal),
  .capVal0 (capVal0),
  .capVal1 (capVal1),
  .irqPulse(irqPulse),
  .strobes (strobes),
  .modeRead(modeRead)
);

// File: tb/sim_capTimer.sv
`timescale 1ns/1ps
module sim_capTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        tick1 = 1'b0, tick4 = 1'b0, tick16 = 1'b0;
  logic        extPin = 1'b0, peerOut = 1'b0, runEn = 1'b0;
  logic [15:0] countVal, capVal0, capVal1;
  logic        matchFlag, irqPulse;

  int checks = 0;
  int errors = 0;
  int pinRises = 0;
  int irqSeen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  capTimer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .tick1(tick1), .tick4(tick4), .tick16(tick16), .extPin(extPin), .peerOut(peerOut),
    .runEn(runEn), .countVal(countVal), .capVal0(capVal0), .capVal1(capVal1),
    .matchFlag(matchFlag), .irqPulse(irqPulse)
  );

  // reference model: pin histories hold the last three sampled pin values
  int mCnt, mCmp, mCap0, mCap1, mMode;
  bit pinH[3];
  bit peerH[3];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mCap0 = 0; mCap1 = 0; mMode = 0;
      foreach (pinH[i]) begin pinH[i] = 0; peerH[i] = 0; end
    end else begin
      bit pRise, pFall, qRise, qFall, tick, sw;
      int src, cm, nCnt, nCap0, nCap1;
      pRise = pinH[1] && !pinH[2];
      pFall = !pinH[1] && pinH[2];
      qRise = peerH[1] && !peerH[2];
      qFall = !peerH[1] && peerH[2];
      src = mMode % 4;
      cm = (mMode / 8) % 4;
      tick = (src == 0) ? pRise : (src == 1) ? tick1 : (src == 2) ? tick4 : tick16;
      nCnt = mCnt;
      if (runEn && tick) begin
        if (((mMode / 4) % 2 == 1) && mCnt == mCmp) nCnt = 0;
        else nCnt = (mCnt + 1) % 65536;
      end
      sw = wrEn && addr == 0 && !wrData[5];
      nCap0 = mCap0; nCap1 = mCap1;
      if (sw) nCap0 = mCnt;
      if ((cm == 1 || cm == 2) && pRise) nCap0 = mCnt;
      if (cm == 2 && pFall) nCap1 = mCnt;
      if (cm == 3 && qRise) nCap0 = mCnt;
      if (cm == 3 && qFall) nCap1 = mCnt;
      if (wrEn && addr == 0) mMode = wrData[4:0];
      if (wrEn && addr == 1) mCmp = wrData;
      mCnt = nCnt; mCap0 = nCap0; mCap1 = nCap1;
      pinH[2] = pinH[1]; pinH[1] = pinH[0]; pinH[0] = extPin;
      peerH[2] = peerH[1]; peerH[1] = peerH[0]; peerH[0] = peerOut;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // clock-by-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 counter vs model", countVal, mCnt);
      chk("R6 R7 R8 capture0 vs model", capVal0, mCap0);
      chk("R7 R8 capture1 vs model", capVal1, mCap1);
      chk("R4 matchFlag vs model", matchFlag, (mCnt == mCmp) ? 1 : 0);
      chk("R10 irqPulse vs model", irqPulse, (pinH[1] && !pinH[2]) ? 1 : 0);
      if (irqPulse) irqSeen++;
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = 16'd0;
  endtask

  task automatic readChk(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdData, exp);
  endtask

  task automatic pulseTick(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick1 = (which == 1); tick4 = (which == 4); tick16 = (which == 16);
      @(negedge clk);
      tick1 = 0; tick4 = 0; tick16 = 0;
    end
  endtask

  task automatic pinCycle(input bit usePeer);
    @(negedge clk); if (usePeer) peerOut = 1'b1; else begin extPin = 1'b1; pinRises++; end
    repeat (6) @(negedge clk);
    if (usePeer) peerOut = 1'b0; else extPin = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int held, v0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk("R1 mode after reset", 3'd0, 32'h20);
    readChk("R1 counter after reset", 3'd4, 0);
    readChk("R1 compare after reset", 3'd1, 0);
    chk("R1 capture0 after reset", capVal0, 0);
    chk("R1 capture1 after reset", capVal1, 0);

    // R4 clear on match at compare 3
    runEn = 1'b1;
    regWrite(3'd1, 16'd3);
    regWrite(3'd0, 16'h25);
    pulseTick(1, 3);
    chk("R4 matchFlag at compare", matchFlag, 1);
    pulseTick(1, 1);
    chk("R4 cleared on match", countVal, 0);
    pulseTick(1, 1);
    chk("R4 counts after clear", countVal, 1);

    // R2 source selection
    regWrite(3'd0, 16'h21);
    pulseTick(1, 5); pulseTick(4, 3); pulseTick(16, 2);
    chk("R2 tick1 source", countVal, 6);
    regWrite(3'd0, 16'h22);
    pulseTick(4, 2); pulseTick(1, 2); pulseTick(16, 1);
    chk("R2 tick4 source", countVal, 8);
    regWrite(3'd0, 16'h23);
    pulseTick(16, 1); pulseTick(1, 3);
    chk("R2 tick16 source", countVal, 9);
    regWrite(3'd0, 16'h20);
    pulseTick(1, 2);
    pinCycle(0);
    chk("R2 pin source counts rising edge", countVal, 10);
    // R5 no capture in mode 00
    chk("R5 capture0 untouched", capVal0, 0);
    chk("R5 capture1 untouched", capVal1, 0);

    // R3 stopped counter
    runEn = 1'b0;
    regWrite(3'd0, 16'h21);
    pulseTick(1, 3);
    chk("R3 held while stopped", countVal, 10);

    // R6 rising capture with counter running
    runEn = 1'b1;
    regWrite(3'd0, 16'h29);
    tick1 = 1'b1;
    pinCycle(0);
    chk("R6 capture0 loaded", capVal0, mCap0);
    chk("R6 capture0 nonzero", (capVal0 != 0) ? 1 : 0, 1);
    chk("R6 capture1 untouched", capVal1, 0);

    // R7 both edges of extPin
    regWrite(3'd0, 16'h31);
    tick1 = 1'b1;
    pinCycle(0);
    chk("R7 capture0 on rise", capVal0, mCap0);
    chk("R7 capture1 on fall", capVal1, mCap1);
    chk("R7 fall later than rise", (capVal1 > capVal0) ? 1 : 0, 1);

    // R8 peer edges, extPin ignored
    regWrite(3'd0, 16'h39);
    tick1 = 1'b1;
    held = capVal0;
    v0 = capVal1;
    pinCycle(0);
    chk("R8 extPin ignored cap0", capVal0, held);
    chk("R8 extPin ignored cap1", capVal1, v0);
    pinCycle(1);
    chk("R8 peer rise capture0", capVal0, mCap0);
    chk("R8 peer fall capture1", capVal1, mCap1);
    chk("R8 peer fall after rise", (capVal1 > capVal0) ? 1 : 0, 1);
    tick1 = 1'b0;

    // R9 software capture
    runEn = 1'b0;
    readChk("R9 bit5 reads one", 3'd0, 32'h39);
    held = countVal;
    regWrite(3'd0, 16'h19);
    chk("R9 software capture", capVal0, held);
    runEn = 1'b1;
    pulseTick(1, 4);
    runEn = 1'b0;
    regWrite(3'd0, 16'h39);
    chk("R9 write of one no capture", capVal0, held);
    chk("R9 counter moved on", countVal, (held + 4) % 65536);

    // R11 top bits ignored
    regWrite(3'd0, 16'hF9);
    readChk("R11 top bits read zero", 3'd0, 32'h39);

    // R12 read map
    readChk("R12 compare read", 3'd1, 3);
    readChk("R12 capture0 read", 3'd2, mCap0);
    readChk("R12 capture1 read", 3'd3, mCap1);
    readChk("R12 counter read", 3'd4, mCnt);
    readChk("R12 unused address", 3'd6, 0);

    // R4 free-run wrap
    regWrite(3'd0, 16'h21);
    runEn = 1'b1;
    @(negedge clk);
    v0 = countVal;
    tick1 = 1'b1;
    repeat (65536) @(negedge clk);
    tick1 = 1'b0;
    chk("R4 wrap returns to start", countVal, v0);

    // R10 interrupt count
    repeat (5) @(negedge clk);
    chk("R10 one pulse per rise", irqSeen, pinRises);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule